// File: doc/BRIEF.md
# Serial boot-mode programming sequencer

This block is the command engine of a serial boot loader. It sits between a byte-wide receive/transmit pair (valid/ready on both sides) and a flash-control port. After reset it stays silent until an external rate detector strobes that the baud rate is locked. It then answers host inquiries, runs an automatic erase of the whole array once the host closes the inquiry phase, and finally serves program, block-erase, sum-check, blank-check, read and status commands in a loop.

Program and erase requests are open-ended sessions. A program session takes records: a 4-byte big-endian address, then a fixed number of data bytes. An erase session takes one block number per byte. An all-ones address or block number closes the session. Every flash request is held until the flash port answers done, and no host byte is taken while a request is pending or a reply is still queued.

Top module: `boot_seq`

## Requirements
- R1: After reset `rx_ready_o` stays low, `tx_valid_o` and `fl_req_o` are low, and no byte is taken until `baud_lock_i` pulses. The block then enters the inquiry phase.
- R2: In the inquiry phase, command 0x20 answers 0x06 then AW (log2 of the byte count). 0x21 answers 0x06 then BW (log2 of the block count). 0x22 answers 0x06 then BASE_PAGE. 0x23 answers 0x06 then 0x01.
- R3: Command 0x40 in the inquiry phase answers 0x06 and then erases the whole array (op 0) without a further host byte. Only after that erase completes does the block accept commands of the command phase.
- R4: Command 0x43 answers 0x06 and opens a program session. Each record is 4 address bytes, most significant first, followed by DB data bytes. The data bytes are written to address A, A+1, ... using the low AW bits of A, modulo the array size. Each record is answered with 0x06 once its last byte is written.
- R5: The program address 0xFFFFFFFF answers 0x06 and returns to the command phase. An address differing from it in any bit, for example 0xFFFFFFFE, is a normal record.
- R6: Command 0x48 answers 0x06 and opens an erase session. A block number below 2^BW erases that block to 0xFF and answers 0x06. 0xFF answers 0x06 and returns to the command phase. Any other number answers 0xC8 and the session stays open.
- R7: Command 0x4B answers 0x06, then the sum modulo 256 of all array bytes.
- R8: Command 0x4D answers 0x06 if every array byte reads 0xFF, otherwise 0xCD.
- R9: Command 0x52 followed by 4 address bytes answers 0x06, then the byte at the low AW address bits. In the inquiry phase, before the full erase, 0x52 is refused at once with 0xD2 and takes no address bytes.
- R10: Command 0x4F in the command phase answers 0x06, then the last error byte sent since reset (0x00 if none).
- R11: An unrecognised command byte c is answered with 0x80|c and leaves the phase unchanged.
- R12: The flash op codes are 0 erase-all, 1 erase-block, 2 program byte, 3 read. `fl_req_o` holds with stable op, address and data until `fl_done_i`. `busy_o` follows `fl_req_o`, and `rx_ready_o` is low while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_lock_i | input | 1 | Strobe from the rate detector: baud rate locked |
| rx_valid_i | input | 1 | Host byte valid |
| rx_data_i | input | 8 | Host byte |
| rx_ready_o | output | 1 | Block takes the host byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Transmitter takes the reply byte |
| fl_req_o | output | 1 | Flash request pending |
| fl_op_o | output | 2 | Flash operation code (see R12) |
| fl_addr_o | output | AW | Flash byte address; block base for block erase |
| fl_wdata_o | output | 8 | Byte to program |
| fl_rdata_i | input | 8 | Read data, valid with fl_done_i |
| fl_done_i | input | 1 | Flash operation complete |
| busy_o | output | 1 | Flash operation in progress |

## Verification
A sum check pushes its result byte in the same cycle in which the queued 0x06 may be leaving on the transmit side. Likewise, a flash done can coincide with a reply handshake. The bench provokes both overlaps by stalling `tx_ready_i` at random and giving the flash model a random latency of 0 to 3 cycles. It judges them by comparing the full reply byte stream, byte for byte, against replies computed from a mirror of the array. It also watches every cycle for a host byte being taken while a flash request is pending.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [3:0] {
    S_BAUD, S_INQ, S_ERALL, S_CMD, S_PADDR, S_PDATA, S_PWAIT,
    S_EBLK, S_EWAIT, S_SCAN, S_RADDR, S_RWAIT
  } state_t;

  typedef enum logic [1:0] {
    OP_ERASE_ALL = 2'd0, OP_ERASE_BLK = 2'd1, OP_PROG = 2'd2, OP_READ = 2'd3
  } fl_op_t;

  localparam logic [7:0] ACK       = 8'h06;
  localparam logic [7:0] ERR       = 8'h80;
  localparam logic [7:0] C_SIZE    = 8'h20;
  localparam logic [7:0] C_CFG     = 8'h21;
  localparam logic [7:0] C_BASE    = 8'h22;
  localparam logic [7:0] C_SUPP    = 8'h23;
  localparam logic [7:0] C_INQ_END = 8'h40;
  localparam logic [7:0] C_PROG    = 8'h43;
  localparam logic [7:0] C_ERASE   = 8'h48;
  localparam logic [7:0] C_SUM     = 8'h4B;
  localparam logic [7:0] C_BLANK   = 8'h4D;
  localparam logic [7:0] C_STAT    = 8'h4F;
  localparam logic [7:0] C_READ    = 8'h52;
endpackage

// File: rtl/boot_shift.sv
module boot_shift #(
  parameter int NB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [7:0]        byte_i,
  output logic [8*(NB-1)-1:0] word_o,
  output logic              last_o
);
  localparam int CW = $clog2(NB);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(NB-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_o <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      word_o <= {word_o[8*(NB-1)-1:0], byte_i} >> 0;
      cnt_q  <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/boot_txq.sv
module boot_txq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       two_i,
  input  logic [7:0] b0_i,
  input  logic [7:0] b1_i,
  input  logic       pop_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       empty_o
);
  logic [7:0] q0_q, q1_q, q0_d, q1_d;
  logic [1:0] cnt_q, cnt_d;

  assign valid_o = (cnt_q != 2'd0);
  assign empty_o = (cnt_q == 2'd0);
  assign data_o  = q0_q;

  always_comb begin
    q0_d  = q0_q;
    q1_d  = q1_q;
    cnt_d = cnt_q;
    if (pop_i && cnt_q != 2'd0) begin
      q0_d  = q1_q;
      cnt_d = cnt_q - 2'd1;
    end
    if (push_i) begin
      if (cnt_d == 2'd0) begin
        q0_d = b0_i;
        q1_d = b1_i;
      end else begin
        q1_d = b0_i;
      end
      cnt_d = cnt_d + (two_i ? 2'd2 : 2'd1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q0_q  <= '0;
      q1_q  <= '0;
      cnt_q <= '0;
    end else begin
      q0_q  <= q0_d;
      q1_q  <= q1_d;
      cnt_q <= cnt_d;
    end
  end

  // R7: result push may meet a pending ACK; two entries must suffice
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ({1'b0, cnt_q} - {2'b0, pop_i} + {2'b0, two_i} + 3'd1) <= 3'd2);
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int         AW        = 8,
  parameter int         BW        = 2,
  parameter int         DB        = 4,
  parameter int         AB        = 4,
  parameter logic [7:0] BASE_PAGE = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_lock_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          fl_req_o,
  output logic [1:0]    fl_op_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  input  logic [7:0]    fl_rdata_i,
  input  logic          fl_done_i,
  output logic          busy_o
);
  localparam int NBLK   = 1 << BW;
  localparam int BLK_SH = AW - BW;
  localparam int IW     = (DB > 1) ? $clog2(DB) : 1;

  state_t        st_q, st_d;
  logic          req_q, req_d;
  fl_op_t        op_q, op_d;
  logic [AW-1:0] addr_q, addr_d, rec_q, rec_d, scan_q, scan_d;
  logic [7:0]    wdat_q, wdat_d, sum_q, sum_d, err_q, err_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          blank_q, blank_d, mode_q, mode_d, erased_q, erased_d;

  logic          push, push2, sh_ld, sh_clr, sh_last, txq_empty, rx_fire, consume;
  logic [7:0]    pb0, pb1, sum_n;
  logic [8*(AB-1)-1:0] sh_word;
  logic [8*AB-1:0]     full_word;

  boot_shift #(.NB(AB)) u_shift (
    .clk_i, .rst_ni, .clr_i(sh_clr), .ld_i(sh_ld), .byte_i(rx_data_i),
    .word_o(sh_word), .last_o(sh_last)
  );

  boot_txq u_txq (
    .clk_i, .rst_ni, .push_i(push), .two_i(push2), .b0_i(pb0), .b1_i(pb1),
    .pop_i(tx_valid_o & tx_ready_i), .valid_o(tx_valid_o), .data_o(tx_data_o),
    .empty_o(txq_empty)
  );

  assign full_word = {sh_word, rx_data_i};
  assign consume   = (st_q == S_INQ) || (st_q == S_CMD) || (st_q == S_PADDR) ||
                     (st_q == S_PDATA) || (st_q == S_EBLK) || (st_q == S_RADDR);
  assign rx_ready_o = consume && txq_empty && !req_q;
  assign rx_fire    = rx_valid_i && rx_ready_o;
  assign sum_n      = sum_q + fl_rdata_i;

  assign fl_req_o   = req_q;
  assign fl_op_o    = op_q;
  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = wdat_q;
  assign busy_o     = req_q;

  always_comb begin
    st_d = st_q; req_d = req_q; op_d = op_q; addr_d = addr_q; rec_d = rec_q;
    scan_d = scan_q; wdat_d = wdat_q; sum_d = sum_q; err_d = err_q; idx_d = idx_q;
    blank_d = blank_q; mode_d = mode_q; erased_d = erased_q;
    push = 1'b0; push2 = 1'b0; pb0 = ACK; pb1 = 8'h00; sh_ld = 1'b0; sh_clr = 1'b0;
    unique case (st_q)
      S_BAUD: if (baud_lock_i) st_d = S_INQ;
      S_INQ: if (rx_fire) begin
        push = 1'b1;
        unique case (rx_data_i)
          C_SIZE:    begin push2 = 1'b1; pb1 = 8'(AW); end
          C_CFG:     begin push2 = 1'b1; pb1 = 8'(BW); end
          C_BASE:    begin push2 = 1'b1; pb1 = BASE_PAGE; end
          C_SUPP:    begin push2 = 1'b1; pb1 = 8'h01; end
          C_INQ_END: begin st_d = S_ERALL; req_d = 1'b1; op_d = OP_ERASE_ALL; addr_d = '0; end
          default:   begin pb0 = ERR | rx_data_i; err_d = ERR | rx_data_i; end
        endcase
      end
      S_ERALL: if (fl_done_i) begin req_d = 1'b0; erased_d = 1'b1; st_d = S_CMD; end
      S_CMD: if (rx_fire) begin
        push = 1'b1;
        unique case (rx_data_i)
          C_PROG:  begin st_d = S_PADDR; sh_clr = 1'b1; end
          C_ERASE: st_d = S_EBLK;
          C_SUM, C_BLANK: begin
            push = (rx_data_i == C_SUM);
            mode_d = (rx_data_i == C_BLANK);
            st_d = S_SCAN; scan_d = '0; sum_d = '0; blank_d = 1'b1;
            req_d = 1'b1; op_d = OP_READ; addr_d = '0;
          end
          C_STAT:  begin push2 = 1'b1; pb1 = err_q; end
          C_READ:  begin push = 1'b0; st_d = S_RADDR; sh_clr = 1'b1; end
          default: begin pb0 = ERR | rx_data_i; err_d = ERR | rx_data_i; end
        endcase
      end
      S_PADDR: if (rx_fire) begin
        sh_ld = 1'b1;
        if (sh_last) begin
          if (&full_word) begin push = 1'b1; st_d = S_CMD; end
          else begin rec_d = full_word[AW-1:0]; idx_d = '0; st_d = S_PDATA; end
        end
      end
      S_PDATA: if (rx_fire) begin
        req_d = 1'b1; op_d = OP_PROG; addr_d = rec_q + AW'(idx_q); wdat_d = rx_data_i;
        st_d = S_PWAIT;
      end
      S_PWAIT: if (fl_done_i) begin
        req_d = 1'b0;
        if (idx_q == IW'(DB-1)) begin push = 1'b1; st_d = S_PADDR; end
        else begin idx_d = idx_q + 1'b1; st_d = S_PDATA; end
      end
      S_EBLK: if (rx_fire) begin
        if (rx_data_i == 8'hFF) begin push = 1'b1; st_d = S_CMD; end
        else if ({1'b0, rx_data_i} < 9'(NBLK)) begin
          req_d = 1'b1; op_d = OP_ERASE_BLK;
          addr_d = AW'(rx_data_i[BW-1:0]) << BLK_SH; st_d = S_EWAIT;
        end else begin
          push = 1'b1; pb0 = ERR | C_ERASE; err_d = ERR | C_ERASE;
        end
      end
      S_EWAIT: if (fl_done_i) begin req_d = 1'b0; push = 1'b1; st_d = S_EBLK; end
      S_SCAN: if (fl_done_i) begin
        sum_d   = sum_n;
        blank_d = blank_q && (fl_rdata_i == 8'hFF);
        if (&scan_q) begin
          req_d = 1'b0; st_d = S_CMD; push = 1'b1;
          if (mode_q) pb0 = blank_d ? ACK : (ERR | C_BLANK);
          else        pb0 = sum_n;
          if (mode_q && !blank_d) err_d = ERR | C_BLANK;
        end else begin
          scan_d = scan_q + 1'b1; addr_d = scan_q + 1'b1;
        end
      end
      S_RADDR: if (rx_fire) begin
        sh_ld = 1'b1;
        if (sh_last) begin
          req_d = 1'b1; op_d = OP_READ; addr_d = full_word[AW-1:0]; st_d = S_RWAIT;
        end
      end
      S_RWAIT: if (fl_done_i) begin
        req_d = 1'b0; push = 1'b1; push2 = 1'b1; pb1 = fl_rdata_i; st_d = S_CMD;
      end
      default: st_d = S_BAUD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_BAUD; req_q <= 1'b0; op_q <= OP_ERASE_ALL; addr_q <= '0; rec_q <= '0;
      scan_q <= '0; wdat_q <= '0; sum_q <= '0; err_q <= '0; idx_q <= '0;
      blank_q <= 1'b1; mode_q <= 1'b0; erased_q <= 1'b0;
    end else begin
      st_q <= st_d; req_q <= req_d; op_q <= op_d; addr_q <= addr_d; rec_q <= rec_d;
      scan_q <= scan_d; wdat_q <= wdat_d; sum_q <= sum_d; err_q <= err_d; idx_q <= idx_d;
      blank_q <= blank_d; mode_q <= mode_d; erased_q <= erased_d;
    end
  end

  // R1: the locked state is left only toward the inquiry phase
  p_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == S_BAUD && st_q != S_BAUD) |-> st_q == S_INQ);
  // R3: the full erase runs only once, before the array is marked erased
  p_erall_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o == OP_ERASE_ALL) |-> !erased_q);
  // R9: no read reaches the flash before the full erase is done
  p_read_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o == OP_READ) |-> erased_q);
  // R12: request held with stable fields until done
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_done_i) |=> (fl_req_o && $stable(fl_op_o) &&
                                  $stable(fl_addr_o) && $stable(fl_wdata_o)));
  // R12: no host byte while flash busy
  p_no_rx_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> !rx_ready_o);
endmodule

// File: tb/boot_seq_bench.sv
module boot_seq_bench;
  localparam int AW = 8, BW = 2, DB = 4, DEPTH = 1 << AW, BLKSZ = DEPTH >> BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_lock = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0, fl_done = 1'b0;
  logic [7:0] rx_data = '0, fl_rdata = '0;
  logic rx_ready, tx_valid, fl_req, busy;
  logic [7:0] tx_data, fl_wdata;
  logic [1:0] fl_op;
  logic [AW-1:0] fl_addr;

  int checks = 0, fails = 0, cyc = 0, busy_rx_viol = 0, fl_ops = 0;
  logic [7:0] fmem [DEPTH];
  logic [7:0] refm [DEPTH];
  logic [7:0] txlog [4096];
  int wr = 0, rd = 0;

  always #4 clk = ~clk;

  boot_seq #(.AW(AW), .BW(BW), .DB(DB)) u_boot_seq (
    .clk_i(clk), .rst_ni(rst_n), .baud_lock_i(baud_lock), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_ready_i(tx_ready), .fl_req_o(fl_req), .fl_op_o(fl_op), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata), .fl_done_i(fl_done), .busy_o(busy)
  );

  // flash model: random latency, action at done
  logic act = 1'b0;
  int lat = 0;
  always @(posedge clk) begin
    fl_done <= 1'b0;
    if (fl_req && !fl_done && !act) begin
      act <= 1'b1; lat <= int'($urandom_range(0, 3));
    end else if (act) begin
      if (lat == 0) begin
        act <= 1'b0; fl_done <= 1'b1; fl_ops <= fl_ops + 1;
        case (fl_op)
          2'd0: for (int i = 0; i < DEPTH; i++) fmem[i] <= 8'hFF;
          2'd1: for (int i = 0; i < BLKSZ; i++) fmem[int'(fl_addr) + i] <= 8'hFF;
          2'd2: fmem[fl_addr] <= fl_wdata;
          default: fl_rdata <= fmem[fl_addr];
        endcase
      end else lat <= lat - 1;
    end
  end

  // reply capture and busy watch, away from the active edge
  always @(negedge clk) begin
    if (rst_n) tx_ready = ($urandom_range(0, 3) != 0);
    if (tx_valid && tx_ready) begin txlog[wr] = tx_data; wr++; end
    if (fl_req && rx_ready) busy_rx_viol++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d exp 0 (hung)", cyc);
      summary();
    end
  end

  task automatic check(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 3; i >= 0; i--) send(w[8*i +: 8]);
  endtask

  task automatic expect_b(logic [7:0] e, string tag);
    while (rd >= wr) @(negedge clk);
    check(tag, txlog[rd], e);
    rd++;
  endtask

  function automatic logic [7:0] ref_sum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < DEPTH; i++) s = s + refm[i];
    return s;
  endfunction

  function automatic bit ref_blank();
    for (int i = 0; i < DEPTH; i++) if (refm[i] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  task automatic prog_rec(logic [31:0] a);
    logic [7:0] d;
    send_word(a);
    for (int i = 0; i < DB; i++) begin
      d = 8'($urandom);
      refm[(int'(a[AW-1:0]) + i) % DEPTH] = d;
      send(d);
    end
    expect_b(8'h06, "R4 record ack");
  endtask

  task automatic rd_chk(logic [31:0] a);
    send(8'h52); send_word(a);
    expect_b(8'h06, "R9 read ack");
    expect_b(refm[a[AW-1:0]], "R9 read data");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin fmem[i] = 8'($urandom); refm[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check("R1 reset rx_ready", rx_ready, 0);
    check("R1 reset tx_valid", tx_valid, 0);
    check("R1 reset fl_req", fl_req, 0);
    rst_n = 1'b1;
    rx_valid = 1'b1; rx_data = 8'h20;
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); seen += int'(rx_ready); end
      check("R1 no byte before lock", seen, 0);
    end
    rx_valid = 1'b0;
    @(negedge clk); baud_lock = 1'b1; @(negedge clk); baud_lock = 1'b0;

    send(8'h20); expect_b(8'h06, "R2 size ack"); expect_b(8'(AW), "R2 size");
    send(8'h21); expect_b(8'h06, "R2 cfg ack");  expect_b(8'(BW), "R2 cfg");
    send(8'h22); expect_b(8'h06, "R2 base ack"); expect_b(8'h00, "R2 base");
    send(8'h23); expect_b(8'h06, "R2 supp ack"); expect_b(8'h01, "R2 supp");
    send(8'h52); expect_b(8'hD2, "R9 read refused before erase");
    send(8'h23); expect_b(8'h06, "R9 no address consumed"); expect_b(8'h01, "R9 supp after refuse");
    send(8'h77); expect_b(8'hF7, "R11 unknown in inquiry");
    send(8'h40); expect_b(8'h06, "R3 inquiry end ack");
    send(8'h4F); expect_b(8'h06, "R10 status ack"); expect_b(8'hF7, "R10 last error");
    send(8'h4D); expect_b(8'h06, "R3 array blank after auto erase");
    send(8'h4B); expect_b(8'h06, "R7 sum ack"); expect_b(ref_sum(), "R7 sum erased");

    send(8'h43); expect_b(8'h06, "R4 program ack");
    prog_rec(32'hFFFF_FFFE);
    prog_rec(32'h0000_0000);
    for (int n = 0; n < 12; n++) begin
      logic [31:0] a = $urandom;
      if (a == 32'hFFFF_FFFF) a = 32'h1234_5678;
      prog_rec(a);
    end
    send_word(32'hFFFF_FFFF); expect_b(8'h06, "R5 terminator ack");
    send(8'h4B); expect_b(8'h06, "R5 back in command wait"); expect_b(ref_sum(), "R7 sum programmed");
    send(8'h4D); expect_b(8'hCD, "R8 blank fails");
    rd_chk(32'h0000_00FE); rd_chk(32'hABCD_0001);
    for (int n = 0; n < 8; n++) rd_chk($urandom);

    send(8'h48); expect_b(8'h06, "R6 erase ack");
    send(8'h01); expect_b(8'h06, "R6 block ack");
    for (int i = 0; i < BLKSZ; i++) refm[BLKSZ + i] = 8'hFF;
    send(8'h05); expect_b(8'hC8, "R6 bad block refused");
    send(8'h03); expect_b(8'h06, "R6 session still open");
    for (int i = 0; i < BLKSZ; i++) refm[3*BLKSZ + i] = 8'hFF;
    send(8'hFF); expect_b(8'h06, "R6 terminator ack");
    send(8'h4B); expect_b(8'h06, "R6 sum ack"); expect_b(ref_sum(), "R6 sum after block erase");
    rd_chk(32'h0000_0040); rd_chk(32'h0000_00FF); rd_chk(32'h0000_0000);

    send(8'h11); expect_b(8'h91, "R11 unknown in command wait");
    send(8'h4F); expect_b(8'h06, "R10 status ack 2"); expect_b(8'h91, "R10 last error 2");

    send(8'h48); expect_b(8'h06, "R6 erase ack 2");
    for (int b = 0; b < (1 << BW); b++) begin send(8'(b)); expect_b(8'h06, "R6 block ack all"); end
    for (int i = 0; i < DEPTH; i++) refm[i] = 8'hFF;
    send(8'hFF); expect_b(8'h06, "R6 terminator 2");
    send(8'h4D); expect_b(ref_blank() ? 8'h06 : 8'hCD, "R8 blank pass after full block erase");

    repeat (10) @(negedge clk);
    check("R12 no rx while busy", busy_rx_viol, 0);
    check("R12 flash ops seen", int'(fl_ops > 0), 1);
    check("R12 busy follows req", int'(busy == fl_req), 1);
    check("R11 no stray replies", wr - rd, 0);
    summary();
  end
endmodule